// File: doc/BRIEF.md
# Sigma-Delta Bitstream Integrator

This block demodulates the one-bit output of a sigma-delta modulator into a signed 16-bit integration result. While an integration phase is active, a prescaler divides the bus clock down to a sample tick. On every tick the block looks at the synchronized modulator bit and moves the accumulator one step: up for a 1, down for a 0. The final value after a phase is the imbalance between ones and zeros seen during that phase. The sample rate is meant to fall between 500 kHz and 2 MHz, and the divide select should be chosen for that.

If a step would leave the signed range, the block does not wrap. The step is refused, a sticky over/underflow flag is raised and the value stays frozen for the rest of that phase. Only an attempted step past a limit freezes the value. Arriving exactly on a limit does not. The flag drives an interrupt request when the interrupt enable is high. The flag is cleared through a clear strobe. The next phase starts again from zero.

The controller has three states. ST_IDLE waits with the value held. Taking the transition START (phase_en sampled high) enters ST_INTEG and clears the value. ST_INTEG steps on each tick. The transition LIMIT_HIT (a step refused at a limit) moves it to ST_FROZEN, and the transition PHASE_END (phase_en sampled low) returns it to ST_IDLE. ST_FROZEN holds the value and leaves only through PHASE_END.

Top module: `sdm_integrator`

## Requirements
- R1: The value is 16-bit two's complement, is 0x0000 after reset, and is set to 0x0000 on the clock edge where phase_en is first sampled high after being low (START).
- R2: While phase_en is low the value does not change, whatever mod_bit does, and the result of the last phase stays readable.
- R3: Counting the START edge as edge 0, sample ticks occur on edges k where (k+1) is a multiple of 2^(div_sel+1). The divider restarts at each START.
- R4: mod_bit passes through two flip-flops, so a tick on edge k uses the mod_bit level present at edge k-2. A 1 adds one to the value and a 0 subtracts one.
- R5: A tick with bit 1 while the value is 0x7FFF leaves the value at 0x7FFF and sets ovf_flag on that edge.
- R6: A tick with bit 0 while the value is 0x8000 leaves the value at 0x8000 and sets ovf_flag on that edge.
- R7: After a refused step, the value stays frozen until phase_en goes low. The next phase begins from 0x0000 as in R1.
- R8: Reaching 0x7FFF or 0x8000 without a refused step does not freeze the value. A following step back toward zero is applied.
- R9: ovf_flag stays set across phases until flag_clr is sampled high. It is then low after that edge, unless a new refused step happens on the same edge, in which case setting wins.
- R10: irq is high exactly when ovf_flag is high and ovf_ie is high. Changing ovf_ie takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_bit | input | 1 | Asynchronous one-bit modulator output |
| div_sel | input | 3 | Prescaler select, divide ratio 2^(div_sel+1) |
| phase_en | input | 1 | High while an integration phase is active |
| ovf_ie | input | 1 | Over/underflow interrupt enable |
| flag_clr | input | 1 | Clears ovf_flag when sampled high |
| acc_value | output | 16 | Signed integration result |
| ovf_flag | output | 1 | Sticky over/underflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is a value sitting exactly on a limit, followed first by a step away and then by a refused step inside the same phase. Reaching it takes 32767 net up-steps with exact control over which bit each tick sees. The bench drives mod_bit cycle by cycle from a pattern function. It uses the fastest divide setting, keeps a reference model that applies the two-cycle synchronizer latency, and sets the pattern boundaries so the value lands on 0x7FFF, steps back twice, climbs again and then hits the limit. A probe in the middle of the phase confirms the step away. A long run of zeros brings out the underflow in the same way.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INTEG  = 2'd1,
        ST_FROZEN = 2'd2
    } integ_state_e;

endpackage

// File: rtl/sdm_sync2.sv
module sdm_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sdm_tick_gen.sv
module sdm_tick_gen #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             tick_o
);

    localparam int                CNT_W   = 1 << SEL_W;
    localparam logic [SEL_W-1:0]  SH_MAX  = SEL_W'(CNT_W - 1);
    localparam logic [CNT_W-1:0]  CNT_ONE = 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // limit = 2^(sel+1) - 1, a mask of sel+1 ones
    assign limit  = {CNT_W{1'b1}} >> (SH_MAX - div_sel_i);
    assign tick_o = run_i && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R3

endmodule

// File: rtl/sdm_acc_fsm.sv
module sdm_acc_fsm
    import sdm_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_en_i,
    input  logic             tick_i,
    input  logic             samp_bit_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             limit_evt_o
);

    localparam logic [ACC_W-1:0] MAX_P   = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_N   = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] ACC_ONE = 1;

    integ_state_e     state_q, state_d;
    logic [ACC_W-1:0] acc_q, acc_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // value register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d     = state_q;
        acc_d       = acc_q;
        limit_evt_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (phase_en_i) begin          // START
                    state_d = ST_INTEG;
                    acc_d   = '0;
                end
            end
            ST_INTEG: begin
                if (!phase_en_i) begin         // PHASE_END
                    state_d = ST_IDLE;
                end else if (tick_i) begin
                    if ((samp_bit_i && acc_q == MAX_P) ||
                        (!samp_bit_i && acc_q == MIN_N)) begin  // LIMIT_HIT
                        state_d     = ST_FROZEN;
                        limit_evt_o = 1'b1;
                    end else if (samp_bit_i) begin
                        acc_d = acc_q + ACC_ONE;
                    end else begin
                        acc_d = acc_q - ACC_ONE;
                    end
                end
            end
            ST_FROZEN: begin
                if (!phase_en_i) begin         // PHASE_END
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign acc_o = acc_q;

    AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && phase_en_i) |=> (acc_q == '0)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_en_i |=> $stable(acc_q)); // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTEG && phase_en_i && tick_i && samp_bit_i && acc_q != MAX_P)
        |=> (acc_q == $past(acc_q) + ACC_ONE)); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTEG && phase_en_i && tick_i && !samp_bit_i && acc_q != MIN_N)
        |=> (acc_q == $past(acc_q) - ACC_ONE)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTEG && phase_en_i && tick_i && samp_bit_i && acc_q == MAX_P)
        |=> (state_q == ST_FROZEN && acc_q == MAX_P)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTEG && phase_en_i && tick_i && !samp_bit_i && acc_q == MIN_N)
        |=> (state_q == ST_FROZEN && acc_q == MIN_N)); // R6
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN) |=> $stable(acc_q)); // R7
    AST_LIMIT_NO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTEG && phase_en_i && tick_i && !samp_bit_i && acc_q == MAX_P)
        |=> (state_q == ST_INTEG && acc_q == MAX_P - ACC_ONE)); // R8

endmodule

// File: rtl/sdm_flag_irq.sv
module sdm_flag_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q && ie_i;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q); // R9

endmodule

// File: rtl/sdm_integrator.sv
module sdm_integrator #(
    parameter int ACC_W       = 16,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_bit,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             phase_en,
    input  logic             ovf_ie,
    input  logic             flag_clr,
    output logic [ACC_W-1:0] acc_value,
    output logic             ovf_flag,
    output logic             irq
);

    logic samp_bit;
    logic tick;
    logic limit_evt;

    sdm_sync2 #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mod_bit),
        .sync_o  (samp_bit)
    );

    sdm_tick_gen #(
        .SEL_W (SEL_W)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (phase_en),
        .div_sel_i (div_sel),
        .tick_o    (tick)
    );

    sdm_acc_fsm #(
        .ACC_W (ACC_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_en_i  (phase_en),
        .tick_i      (tick),
        .samp_bit_i  (samp_bit),
        .acc_o       (acc_value),
        .limit_evt_o (limit_evt)
    );

    sdm_flag_irq u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (limit_evt),
        .clr_i  (flag_clr),
        .ie_i   (ovf_ie),
        .flag_o (ovf_flag),
        .irq_o  (irq)
    );

endmodule

// File: tb/sim_sdm_integrator.sv
module sim_sdm_integrator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_bit = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic        phase_en = 1'b0;
    logic        ovf_ie = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] acc_value;
    logic        ovf_flag;
    logic        irq;

    always #5 clk = ~clk;

    sdm_integrator u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_bit   (mod_bit),
        .div_sel   (div_sel),
        .phase_en  (phase_en),
        .ovf_ie    (ovf_ie),
        .flag_clr  (flag_clr),
        .acc_value (acc_value),
        .ovf_flag  (ovf_flag),
        .irq       (irq)
    );

    typedef struct packed {
        logic [15:0] acc;
        logic        flag;
        logic        irq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    event  phase_done;

    int n_chk  = 0;
    int n_fail = 0;
    int m_acc  = 0;
    bit m_flag = 1'b0;
    bit m_frz  = 1'b0;
    int seg_a  = 0;
    int seg_b  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic bit pat(input int mode, input int k);
        int v;
        case (mode)
            0: return 1'b1;
            1: return k[0];
            2: begin
                v = (k * 7) ^ (k >> 2);
                return v[0];
            end
            3: return (k < seg_a) || (k >= seg_b);
            default: return 1'b0;
        endcase
    endfunction

    // driver: runs one phase cycle by cycle and keeps the reference model
    task automatic run_phase(input int sel, input int mode, input int len,
                             input int probe, input string tag);
        int ratio;
        bit b;
        exp_t e;
        ratio   = 2 << sel;
        div_sel = 3'(sel);
        mod_bit = pat(mode, 0);
        repeat (3) @(negedge clk);
        m_acc = 0;
        m_frz = 1'b0;
        for (int k = 0; k < len; k++) begin
            mod_bit  = pat(mode, k);
            phase_en = 1'b1;
            if (((k + 1) % ratio) == 0 && !m_frz) begin
                b = pat(mode, (k < 2) ? 0 : k - 2);
                if (b && m_acc == 32767) begin
                    m_flag = 1'b1;
                    m_frz  = 1'b1;
                end else if (!b && m_acc == -32768) begin
                    m_flag = 1'b1;
                    m_frz  = 1'b1;
                end else begin
                    m_acc = m_acc + (b ? 1 : -1);
                end
            end
            @(negedge clk);
            if (k == probe)
                chk(acc_value == 16'(m_acc), "R8", "value after stepping off limit",
                    32'(acc_value), 32'(16'(m_acc)));
        end
        phase_en = 1'b0;
        e.acc  = 16'(m_acc);
        e.flag = m_flag;
        e.irq  = m_flag & ovf_ie;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        repeat (2) @(negedge clk);
        -> phase_done;
        @(negedge clk);
    endtask

    // monitor: pops expected results when a phase has finished
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(phase_done);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1", "unexpected result with empty queue", 32'(acc_value), 32'h0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(acc_value == e.acc, t, "phase result", 32'(acc_value), 32'(e.acc));
                chk(ovf_flag == e.flag, t, "flag after phase", 32'(ovf_flag), 32'(e.flag));
                chk(irq == e.irq, "R10", "irq after phase", 32'(irq), 32'(e.irq));
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        chk(acc_value == 16'h0000, "R1", "reset value", 32'(acc_value), 32'h0);
        chk(ovf_flag == 1'b0, "R9", "reset flag", 32'(ovf_flag), 32'h0);
        chk(irq == 1'b0, "R10", "reset irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        ovf_ie = 1'b1;

        run_phase(0, 0, 40, -1, "R3 R4 ones at divide 2");

        held = acc_value;
        for (int i = 0; i < 20; i++) begin
            mod_bit = i[0];
            @(negedge clk);
        end
        chk(acc_value == held, "R2", "value while idle", 32'(acc_value), 32'(held));

        run_phase(2, 4, 64, -1, "R1 R3 restart, zeros at divide 8");
        run_phase(1, 2, 100, -1, "R4 mixed bits at divide 4");
        seg_a = 50;
        seg_b = 120;
        run_phase(3, 3, 300, -1, "R3 R4 segments at divide 16");
        run_phase(0, 1, 40, -1, "R4 alternating bits");

        ovf_ie = 1'b0;
        seg_a  = 65533;
        seg_b  = 65537;
        run_phase(0, 3, 65560, 65537, "R5 R7 R8 overflow");
        ovf_ie = 1'b1;
        #1;
        chk(irq == 1'b1, "R10", "irq follows enable", 32'(irq), 32'h1);
        @(negedge clk);

        run_phase(1, 0, 20, -1, "R7 R9 restart after freeze");

        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_flag   = 1'b0;
        chk(ovf_flag == 1'b0, "R9", "flag after clear", 32'(ovf_flag), 32'h0);
        chk(irq == 1'b0, "R10", "irq after clear", 32'(irq), 32'h0);

        run_phase(0, 4, 65545, -1, "R6 R7 underflow");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "all phases compared", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule